// File: doc/BRIEF.md
# Masked Priority Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt lines from board peripherals and turns them into one 4-bit interrupt level for a processor. Every line owns a fixed bit in a 16-bit pending word. That word is ANDed with a software-programmed enable word. Among the sources that are both pending and enabled, the one with the lowest priority number wins. Its number is inverted before it leaves the block, so the output is 0 when nothing is requesting and 15 for the most urgent source.

Software reaches the block through a small 16-bit register window addressed by byte offset. The window holds the enable word and two plain storage registers: a power-control word and a general output word, both of which drive output pins. It also holds a constant identification word. Four add-in card slots feed their interrupt lines through a fixed routing helper onto the four shared card interrupt sources, so a slot interrupt behaves exactly like the matching dedicated line.

Top module: `irlx_top`

## Requirements
- R1: After reset the enable word, the power word, the output word and the read data are all 0, and `irl_o` is 0.
- R2: Each pending bit follows its source line with one clock of delay. A high line sets the bit and a low line clears it, with no edge capture.
- R3: Source index k of `periph_irq_i` has priority k and enable bit B(k), where B = 11,9,8,12,10,6,5,4,7,14,13,0,15 for k = 0..12. The winner is the smallest k that is pending with B(k) set in the enable word.
- R4: `irl_o` equals the winning priority XOR 15. It is registered, and changes one clock after the pending word or the enable word changes, so it trails a source line by two clocks.
- R5: When no source is both pending and enabled, `irl_o` is 0.
- R6: The enable word sits at byte offset 0x00 and can be read and written. A write changes `irl_o` on the following clock, without any source line changing.
- R7: The power word at offset 0x30 and the output word at offset 0x36 can be read and written, and they drive `pwr_o` and `oport_o`.
- R8: A read of offset 0x32 returns 0x0010. Writes to 0x32 are discarded.
- R9: A read of any other offset returns 0. A write to any other offset changes no register and no output.
- R10: Read data appears on `bus_rdata` on the clock after the request and holds until the next read.
- R11: A pending source whose enable bit is 0 has no effect on `irl_o`.
- R12: Slot lines 0, 1, 2 and 3 of `slot_irq_i` act as the sources of priority 9, 10, 3 and 0 respectively. Each slot line is ORed with the matching `periph_irq_i` line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq_i | input | 13 | Peripheral interrupt lines, indexed by priority |
| slot_irq_i | input | 4 | Card slot interrupt lines, indexed by slot |
| bus_vld | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| pwr_o | output | 16 | Power word contents |
| oport_o | output | 16 | Output word contents |
| irl_o | output | 4 | Encoded interrupt level, 0 when idle |

## Verification
The first pass raises each source alone with every enable bit set. This shows that each of the thirteen priority numbers is produced from its own line and its own irregular enable bit. The second pass raises several sources together, chosen so that the winner is neither the lowest nor the highest index. This separates a true minimum search from first-bit or last-bit logic. The third pass keeps every line high and changes only the enable word, which proves that masking is done through the table pairing and not by index. The last pass drives the slot lines alone, which separates the slot routing from the dedicated lines.

// File: rtl/irlx_pkg.sv
package irlx_pkg;
  localparam int N_SRC  = 13;
  localparam int DW     = 16;
  localparam int AW     = 6;
  localparam int LW     = 4;
  localparam int N_SLOT = 4;

  localparam logic [LW-1:0] LVL_IDLE = {LW{1'b1}};

  localparam logic [AW-1:0] ADR_MASK = 6'h00;
  localparam logic [AW-1:0] ADR_PWR  = 6'h30;
  localparam logic [AW-1:0] ADR_VER  = 6'h32;
  localparam logic [AW-1:0] ADR_OUT  = 6'h36;
  localparam logic [DW-1:0] VER_VAL  = 16'h0010;

  // priority numbers of the four shared card interrupt sources, A..D
  localparam int LVL_CARD_A = 9;
  localparam int LVL_CARD_B = 10;
  localparam int LVL_CARD_C = 3;
  localparam int LVL_CARD_D = 0;

  // enable/pending bit position owned by the source of priority lvl
  function automatic int unsigned bit_of(input int unsigned lvl);
    case (lvl)
      0:       return 11;
      1:       return 9;
      2:       return 8;
      3:       return 12;
      4:       return 10;
      5:       return 6;
      6:       return 5;
      7:       return 4;
      8:       return 7;
      9:       return 14;
      10:      return 13;
      11:      return 0;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/irlx_regs.sv
module irlx_regs
  import irlx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_vld,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] pwr_o,
  output logic [DW-1:0] oport_o
);
  logic [DW-1:0] mask_q, pwr_q, oport_q, rd_q;
  logic [DW-1:0] rd_d;
  logic          wr_en, rd_en;
  logic          mask_en, pwr_en, oport_en;

  assign wr_en = bus_vld & bus_we;
  assign rd_en = bus_vld & ~bus_we;

  // write enables per register; other offsets, including 0x32, fall through
  always_comb begin
    mask_en  = wr_en && (bus_addr == ADR_MASK);
    pwr_en   = wr_en && (bus_addr == ADR_PWR);
    oport_en = wr_en && (bus_addr == ADR_OUT);
  end

  // read decode
  always_comb begin
    case (bus_addr)
      ADR_MASK: rd_d = mask_q;
      ADR_PWR:  rd_d = pwr_q;
      ADR_VER:  rd_d = VER_VAL;
      ADR_OUT:  rd_d = oport_q;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      pwr_q   <= '0;
      oport_q <= '0;
      rd_q    <= '0;
    end else begin
      if (mask_en)  mask_q  <= bus_wdata;
      if (pwr_en)   pwr_q   <= bus_wdata;
      if (oport_en) oport_q <= bus_wdata;
      if (rd_en)    rd_q    <= rd_d;
    end
  end

  assign bus_rdata = rd_q;
  assign mask_o    = mask_q;
  assign pwr_o     = pwr_q;
  assign oport_o   = oport_q;
endmodule

// File: rtl/irlx_pending.sv
module irlx_pending
  import irlx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] lines_i,
  output logic [DW-1:0]    pend_o
);
  logic [DW-1:0] pend_d, pend_q;

  // scatter each priority-ordered line to its own bit of the word
  always_comb begin
    pend_d = '0;
    for (int k = 0; k < N_SRC; k++) begin
      pend_d[bit_of(k)] = lines_i[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irlx_encoder.sv
module irlx_encoder
  import irlx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pend_i,
  input  logic [DW-1:0] mask_i,
  output logic [LW-1:0] irl_o
);
  logic [DW-1:0] hit;
  logic [LW-1:0] sel, irl_d, irl_q;

  assign hit = pend_i & mask_i;

  // walk from the weakest source down so the smallest priority wins
  always_comb begin
    sel = LVL_IDLE;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (hit[bit_of(k)]) sel = LW'(k);
    end
    irl_d = sel ^ LVL_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irl_q <= '0;
    else        irl_q <= irl_d;
  end

  assign irl_o = irl_q;
endmodule

// File: rtl/irlx_slot_route.sv
module irlx_slot_route
  import irlx_pkg::*;
(
  input  logic [N_SLOT-1:0] slot_i,
  output logic [3:0]        card_o   // A, B, C, D
);
  // slot s lands on shared line s mod 4; several slots may share one
  always_comb begin
    card_o = '0;
    for (int s = 0; s < N_SLOT; s++) begin
      card_o[s % 4] = card_o[s % 4] | slot_i[s];
    end
  end
endmodule

// File: rtl/irlx_top.sv
module irlx_top
  import irlx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] periph_irq_i,
  input  logic [N_SLOT-1:0] slot_irq_i,
  input  logic             bus_vld,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [DW-1:0]    pwr_o,
  output logic [DW-1:0]    oport_o,
  output logic [LW-1:0]    irl_o
);
  // reset asserts at once and releases on the clock
  logic [1:0] rst_sq;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_sync_n = rst_sq[1];

  logic [3:0]       card;
  logic [N_SRC-1:0] src_lines;
  logic [DW-1:0]    pend_q, mask_q;

  irlx_slot_route u_route (
    .slot_i (slot_irq_i),
    .card_o (card)
  );

  always_comb begin
    src_lines = periph_irq_i;
    src_lines[LVL_CARD_A] = periph_irq_i[LVL_CARD_A] | card[0];
    src_lines[LVL_CARD_B] = periph_irq_i[LVL_CARD_B] | card[1];
    src_lines[LVL_CARD_C] = periph_irq_i[LVL_CARD_C] | card[2];
    src_lines[LVL_CARD_D] = periph_irq_i[LVL_CARD_D] | card[3];
  end

  irlx_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_vld   (bus_vld),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask_o    (mask_q),
    .pwr_o     (pwr_o),
    .oport_o   (oport_o)
  );

  irlx_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lines_i (src_lines),
    .pend_o  (pend_q)
  );

  irlx_encoder u_enc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pend_i (pend_q),
    .mask_i (mask_q),
    .irl_o  (irl_o)
  );
endmodule

// File: rtl/irlx_chk.sv
module irlx_chk
  import irlx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] lines,
  input logic             bus_vld,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_rdata,
  input logic [DW-1:0]    pend,
  input logic [DW-1:0]    mask,
  input logic [LW-1:0]    irl
);
  // R2: pending bits trail their lines by one clock
  a_r2_follow_ext: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend[0] == $past(lines[11]));
  a_r2_follow_tp: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend[15] == $past(lines[12]));

  // R3: enabled top source gives the strongest code
  a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[11] && mask[11]) |=> irl == 4'hF);

  // R5: nothing enabled and pending gives the idle code
  a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & mask) == '0) |=> irl == '0);

  // R8: identification word
  a_r8_ver: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_we && bus_addr == ADR_VER) |=> bus_rdata == VER_VAL);

  // R9: undecoded reads return zero
  a_r9_undec: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_we && bus_addr != ADR_MASK && bus_addr != ADR_PWR &&
     bus_addr != ADR_VER && bus_addr != ADR_OUT) |=> bus_rdata == '0);

  // R10: read data holds between reads
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && !bus_we) |=> $stable(bus_rdata));
endmodule

bind irlx_top irlx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .lines     (src_lines),
  .bus_vld   (bus_vld),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pend      (pend_q),
  .mask      (mask_q),
  .irl       (irl_o)
);

// File: tb/sim_irlx_top.sv
module sim_irlx_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] periph;
  logic [3:0]  slot;
  logic        bus_vld, bus_we;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata, pwr_o, oport_o;
  logic [3:0]  irl_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irlx_top u0 (
    .clk(clk), .rst_n(rst_n), .periph_irq_i(periph), .slot_irq_i(slot),
    .bus_vld(bus_vld), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_o(pwr_o),
    .oport_o(oport_o), .irl_o(irl_o)
  );

  // enable bit table from R3
  function automatic int ebit(input int k);
    case (k)
      0: return 11;  1: return 9;   2: return 8;  3: return 12;
      4: return 10;  5: return 6;   6: return 5;  7: return 4;
      8: return 7;   9: return 14;  10: return 13; 11: return 0;
      default: return 15;
    endcase
  endfunction

  function automatic logic [3:0] model(input logic [12:0] src, input logic [15:0] msk);
    int sel = 15;
    for (int k = 12; k >= 0; k--) if (src[k] && msk[ebit(k)]) sel = k;
    return 4'(sel) ^ 4'hF;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_vld = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_vld = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_vld = 0;
    d = bus_rdata;
  endtask

  task automatic drive(input logic [12:0] p, input logic [3:0] s);
    @(negedge clk);
    periph = p; slot = s;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 irl", 16'(irl_o), 16'h0);
    chk("R1 pwr pin", pwr_o, 16'h0);
    chk("R1 out pin", oport_o, 16'h0);
    chk("R1 rdata", bus_rdata, 16'h0);
    rd(6'h00, v); chk("R1 mask", v, 16'h0);
    drive(13'h1FFF, 4'h0);
    chk("R11 all masked after reset", 16'(irl_o), 16'h0);
    drive(13'h0, 4'h0);
  endtask

  task automatic t_each_source;
    wr(6'h00, 16'hFFFF);
    for (int k = 0; k < 13; k++) begin
      drive(13'(1 << k), 4'h0);
      chk("R3 R4 single source", 16'(irl_o), 16'(4'(k) ^ 4'hF));
    end
    drive(13'h0, 4'h0);
    chk("R5 idle after release", 16'(irl_o), 16'h0);
  endtask

  task automatic t_latency;
    @(negedge clk); periph = 13'h0800;          // priority 11
    @(negedge clk);
    chk("R2 R4 not yet after one clock", 16'(irl_o), 16'h0);
    @(negedge clk);
    chk("R2 R4 after two clocks", 16'(irl_o), 16'h4);
    drive(13'h0, 4'h0);
  endtask

  task automatic t_priority;
    logic [12:0] pats [5];
    pats[0] = 13'b1_0000_0010_0000;   // 12,5 -> 5
    pats[1] = 13'b0_1010_0001_0000;   // 11,9,4 -> 4
    pats[2] = 13'b1_1111_1111_1000;   // 3..12 -> 3
    pats[3] = 13'b0_0000_1100_0000;   // 7,6 -> 6
    pats[4] = 13'b1_1000_0000_0001;   // 12,11,0 -> 0
    for (int i = 0; i < 5; i++) begin
      drive(pats[i], 4'h0);
      chk("R3 multi source min", 16'(irl_o), 16'(model(pats[i], 16'hFFFF)));
    end
    drive(13'h0, 4'h0);
  endtask

  task automatic t_mask;
    drive(13'h1FFF, 4'h0);
    wr(6'h00, 16'h8000);              // touch panel only, priority 12
    @(negedge clk);
    chk("R6 R11 mask bit 15 only", 16'(irl_o), 16'h3);
    wr(6'h00, 16'h0001);              // bit 0 -> priority 11
    @(negedge clk);
    chk("R6 mask bit 0 only", 16'(irl_o), 16'h4);
    wr(6'h00, 16'h000E);              // unused bits
    @(negedge clk);
    chk("R11 unused mask bits", 16'(irl_o), 16'h0);
    wr(6'h00, 16'h0800);              // priority 0
    @(negedge clk);
    chk("R6 mask bit 11", 16'(irl_o), 16'hF);
    wr(6'h00, 16'h0000);
    @(negedge clk);
    chk("R5 R11 mask cleared", 16'(irl_o), 16'h0);
    drive(13'h0, 4'h0);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(6'h00, 16'hA5C3);
    wr(6'h30, 16'h1234);
    wr(6'h36, 16'hBEEF);
    rd(6'h00, v); chk("R6 mask readback", v, 16'hA5C3);
    rd(6'h30, v); chk("R7 pwr readback", v, 16'h1234);
    rd(6'h36, v); chk("R7 out readback", v, 16'hBEEF);
    chk("R7 pwr pin", pwr_o, 16'h1234);
    chk("R7 out pin", oport_o, 16'hBEEF);
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", bus_rdata, 16'hBEEF);
  endtask

  task automatic t_version;
    logic [15:0] v;
    rd(6'h32, v); chk("R8 version", v, 16'h0010);
    wr(6'h32, 16'hFFFF);
    rd(6'h32, v); chk("R8 version after write", v, 16'h0010);
  endtask

  task automatic t_undecoded;
    logic [15:0] v;
    wr(6'h02, 16'h7777);
    wr(6'h34, 16'h5555);
    wr(6'h3E, 16'h3333);
    rd(6'h02, v); chk("R9 read 0x02", v, 16'h0);
    rd(6'h34, v); chk("R9 read 0x34", v, 16'h0);
    rd(6'h00, v); chk("R9 mask untouched", v, 16'hA5C3);
    rd(6'h30, v); chk("R9 pwr untouched", v, 16'h1234);
    chk("R9 out pin untouched", oport_o, 16'hBEEF);
  endtask

  task automatic t_slots;
    logic [3:0] exp [4];
    exp[0] = 4'd9 ^ 4'hF; exp[1] = 4'd10 ^ 4'hF;
    exp[2] = 4'd3 ^ 4'hF; exp[3] = 4'd0 ^ 4'hF;
    wr(6'h00, 16'hFFFF);
    for (int s = 0; s < 4; s++) begin
      drive(13'h0, 4'(1 << s));
      chk("R12 slot route", 16'(irl_o), 16'(exp[s]));
    end
    drive(13'h0, 4'b0011);
    chk("R12 slots 0 and 1", 16'(irl_o), 16'(exp[0]));
    drive(13'h0, 4'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; periph = '0; slot = '0;
    bus_vld = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_each_source();
    t_latency();
    t_priority();
    t_mask();
    t_regs();
    t_version();
    t_undecoded();
    t_slots();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule